// File: doc/BRIEF.md
# True-Carry Integer ALU Datapath

This block is the integer arithmetic stage of a small RISC-style core. Each cycle it takes a first operand and a second operand that is picked from an immediate, a plain register value or a register value sent through a barrel shifter. It then forms one of ten operations chosen by an opcode. The result and its write-enable are combinational. Four condition flags (negative, zero, carry, overflow) live in a small register that changes only when the per-operation flag-set input is high.

Subtraction uses true-carry convention: a set carry means no borrow happened. The with-carry subtract forms therefore take one extra unit away when the incoming carry is clear. The reverse-subtract forms swap the operand order, so a reverse subtract of an immediate zero negates the first operand. The two compare forms only set flags. The caller supplies the incoming carry, usually by feeding back the carry flag.

Top module: `tcalu_core`

## Requirements
- R1: Opcode 0 (add) gives A + op2 and opcode 1 (add-with-carry) gives A + op2 + carry_in, both taken modulo 2^W.
- R2: Opcode 2 (subtract) gives A − op2 and opcode 3 (subtract-with-carry) gives A − op2 − (1 − carry_in), both modulo 2^W.
- R3: Opcode 4 (reverse subtract) gives op2 − A and opcode 5 (reverse subtract-with-carry) gives op2 − A − (1 − carry_in). A reverse subtract with an immediate of zero yields −A.
- R4: Opcode 6 (move) outputs op2 unchanged and opcode 7 (move-not) outputs its bitwise inverse.
- R5: Opcode 8 (compare) computes A − op2 and opcode 9 (compare-negative) computes A + op2. Both hold result_we low. Opcodes 0 to 7 drive result_we high.
- R6: On an update from an additive form (0, 1, 9), C takes the carry out of bit W−1. On an update from a subtractive form (2 to 5, 8), C is 1 exactly when the true difference is not negative (no borrow).
- R7: On an update, N takes result bit W−1 and Z is 1 when the result is all zeros. For arithmetic forms, V is 1 when the signed result falls outside the W-bit two's-complement range.
- R8: When set_flags is low, all four flags keep their values on the next clock edge.
- R9: For move and move-not with set_flags high, only N and Z update. C and V keep their values.
- R10: src_sel 0 selects imm, 1 selects reg_b, and 2 or 3 selects reg_b after the barrel shifter.
- R11: sh_kind 0 shifts left logically, 1 shifts right logically, 2 shifts right arithmetically and 3 rotates right, each by sh_amt positions (0 to W−1).
- R12: Opcodes 10 to 15 give result 0 with result_we low and leave all flags unchanged.
- R13: While rst_n is low, all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low synchronous reset of the flags |
| opcode | input | 4 | Operation select (0 to 9 defined) |
| src_sel | input | 2 | Second-operand source select |
| op_a | input | W | First operand |
| reg_b | input | W | Register value for the second operand |
| imm | input | W | Already-decoded immediate |
| sh_kind | input | 2 | Shift kind for the shifted-register source |
| sh_amt | input | log2(W) | Shift distance |
| set_flags | input | 1 | Update flags with this operation |
| carry_in | input | 1 | Incoming carry for the with-carry forms |
| result | output | W | Operation result |
| result_we | output | 1 | Result should be written back |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag (true-carry, set means no borrow) |
| flag_v | output | 1 | Signed overflow flag |

## Verification
The only state in the block is the four-bit flag register. A bad decode or adder fault therefore shows on result in the same cycle, and a bad flag value shows on the flag outputs one edge after the operation that set it. The bench keeps its own flag model. It compares the flags after every vector, so a hold that leaks or a carry with the wrong borrow sense is caught on the very next vector. The sweep runs an 8-bit build across every opcode, both carry-in values and every first-operand value, and it tries every shift kind and distance on every register value.

// File: rtl/tcalu_pkg.sv
package tcalu_pkg;

   typedef enum logic [3:0] {
      OP_ADD = 4'd0,
      OP_ADC = 4'd1,
      OP_SUB = 4'd2,
      OP_SBC = 4'd3,
      OP_RSB = 4'd4,
      OP_RSC = 4'd5,
      OP_MOV = 4'd6,
      OP_MVN = 4'd7,
      OP_CMP = 4'd8,
      OP_CMN = 4'd9
   } alu_op_e;

   typedef enum logic [1:0] {
      SH_LSL = 2'd0,
      SH_LSR = 2'd1,
      SH_ASR = 2'd2,
      SH_ROR = 2'd3
   } shift_e;

   typedef enum logic [1:0] {
      SRC_IMM = 2'd0,
      SRC_REG = 2'd1
   } src_e;

   typedef enum logic [1:0] {
      CI_ZERO = 2'd0,
      CI_ONE  = 2'd1,
      CI_PASS = 2'd2
   } cin_sel_e;

   typedef struct packed {
      logic     inv_a;
      logic     inv_b;
      cin_sel_e cin_sel;
      logic     arith;
      logic     move;
      logic     move_not;
      logic     write;
   } ctrl_t;

   function automatic ctrl_t decode_op(input logic [3:0] op);
      ctrl_t c;
      c = '{inv_a: 1'b0, inv_b: 1'b0, cin_sel: CI_ZERO, arith: 1'b0,
            move: 1'b0, move_not: 1'b0, write: 1'b0};
      case (op)
         OP_ADD: begin c.arith = 1'b1; c.write = 1'b1; end
         OP_ADC: begin c.arith = 1'b1; c.write = 1'b1; c.cin_sel = CI_PASS; end
         OP_SUB: begin c.arith = 1'b1; c.write = 1'b1; c.inv_b = 1'b1; c.cin_sel = CI_ONE; end
         OP_SBC: begin c.arith = 1'b1; c.write = 1'b1; c.inv_b = 1'b1; c.cin_sel = CI_PASS; end
         OP_RSB: begin c.arith = 1'b1; c.write = 1'b1; c.inv_a = 1'b1; c.cin_sel = CI_ONE; end
         OP_RSC: begin c.arith = 1'b1; c.write = 1'b1; c.inv_a = 1'b1; c.cin_sel = CI_PASS; end
         OP_MOV: begin c.move = 1'b1; c.write = 1'b1; end
         OP_MVN: begin c.move = 1'b1; c.write = 1'b1; c.move_not = 1'b1; end
         OP_CMP: begin c.arith = 1'b1; c.inv_b = 1'b1; c.cin_sel = CI_ONE; end
         OP_CMN: begin c.arith = 1'b1; end
         default: ;
      endcase
      return c;
   endfunction

endpackage

// File: rtl/tcalu_shifter.sv
module tcalu_shifter
   import tcalu_pkg::*;
#(
   parameter int W = 32,
   localparam int SW = $clog2(W)
) (
   input  logic [W-1:0]  din,
   input  logic [1:0]    kind,
   input  logic [SW-1:0] amt,
   output logic [W-1:0]  dout
);

   logic [W-1:0] stage [SW+1];

   assign stage[0] = din;

   for (genvar k = 0; k < SW; k++) begin : g_stage
      localparam int D = 1 << k;
      logic [W-1:0] x;
      logic [W-1:0] moved;

      assign x = stage[k];

      always_comb begin
         case (kind)
            SH_LSL:  moved = x << D;
            SH_LSR:  moved = x >> D;
            SH_ASR:  moved = $signed(x) >>> D;
            default: moved = (x >> D) | (x << (W - D));
         endcase
      end

      assign stage[k+1] = amt[k] ? moved : x;
   end

   assign dout = stage[SW];

endmodule

// File: rtl/tcalu_adder.sv
module tcalu_adder #(
   parameter int W = 32
) (
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout,
   output logic         ovf
);

   logic [W:0] full;

   assign full = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
   assign sum  = full[W-1:0];
   assign cout = full[W];
   assign ovf  = (x[W-1] == y[W-1]) && (full[W-1] != x[W-1]);

endmodule

// File: rtl/tcalu_flags.sv
module tcalu_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic upd_nz,
   input  logic upd_cv,
   input  logic n_in,
   input  logic z_in,
   input  logic c_in,
   input  logic v_in,
   output logic n_q,
   output logic z_q,
   output logic c_q,
   output logic v_q
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         n_q <= 1'b0;
         z_q <= 1'b0;
      end else if (upd_nz) begin
         n_q <= n_in;
         z_q <= z_in;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_q <= 1'b0;
         v_q <= 1'b0;
      end else if (upd_cv) begin
         c_q <= c_in;
         v_q <= v_in;
      end
   end

endmodule

// File: rtl/tcalu_core.sv
module tcalu_core
   import tcalu_pkg::*;
#(
   parameter int W = 32,
   localparam int SW = $clog2(W)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [3:0]    opcode,
   input  logic [1:0]    src_sel,
   input  logic [W-1:0]  op_a,
   input  logic [W-1:0]  reg_b,
   input  logic [W-1:0]  imm,
   input  logic [1:0]    sh_kind,
   input  logic [SW-1:0] sh_amt,
   input  logic          set_flags,
   input  logic          carry_in,
   output logic [W-1:0]  result,
   output logic          result_we,
   output logic          flag_n,
   output logic          flag_z,
   output logic          flag_c,
   output logic          flag_v
);

   if (W < 4 || (W & (W - 1)) != 0) begin : g_bad_width
      $error("tcalu_core: W must be a power of two of at least 4");
   end

   ctrl_t        ctrl;
   logic [W-1:0] shifted;
   logic [W-1:0] op2;
   logic [W-1:0] add_x;
   logic [W-1:0] add_y;
   logic         add_cin;
   logic [W-1:0] sum;
   logic         cout;
   logic         ovf;

   assign ctrl = decode_op(opcode);

   tcalu_shifter #(.W(W)) u_shift (
      .din  (reg_b),
      .kind (sh_kind),
      .amt  (sh_amt),
      .dout (shifted)
   );

   always_comb begin
      case (src_sel)
         SRC_IMM: op2 = imm;
         SRC_REG: op2 = reg_b;
         default: op2 = shifted;
      endcase
   end

   always_comb begin
      add_x = ctrl.inv_a ? ~op_a : op_a;
      add_y = ctrl.inv_b ? ~op2 : op2;
      case (ctrl.cin_sel)
         CI_ONE:  add_cin = 1'b1;
         CI_PASS: add_cin = carry_in;
         default: add_cin = 1'b0;
      endcase
   end

   tcalu_adder #(.W(W)) u_add (
      .x    (add_x),
      .y    (add_y),
      .cin  (add_cin),
      .sum  (sum),
      .cout (cout),
      .ovf  (ovf)
   );

   always_comb begin
      if (ctrl.move)
         result = ctrl.move_not ? ~op2 : op2;
      else if (ctrl.arith)
         result = sum;
      else
         result = '0;
   end

   assign result_we = ctrl.write;

   tcalu_flags u_flags (
      .clk    (clk),
      .rst_n  (rst_n),
      .upd_nz (set_flags && (ctrl.arith || ctrl.move)),
      .upd_cv (set_flags && ctrl.arith),
      .n_in   (result[W-1]),
      .z_in   (result == '0),
      .c_in   (cout),
      .v_in   (ovf),
      .n_q    (flag_n),
      .z_q    (flag_z),
      .c_q    (flag_c),
      .v_q    (flag_v)
   );

endmodule

// File: rtl/tcalu_checker.sv
module tcalu_checker #(
   parameter int W = 32
) (
   input logic         clk,
   input logic         rst_n,
   input logic [3:0]   opcode,
   input logic [1:0]   src_sel,
   input logic [W-1:0] reg_b,
   input logic [W-1:0] imm,
   input logic         set_flags,
   input logic [W-1:0] result,
   input logic         result_we,
   input logic         flag_n,
   input logic         flag_z,
   input logic         flag_c,
   input logic         flag_v
);

   AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == 4'd8 || opcode == 4'd9) |-> !result_we); // R5
   AST_OPS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode <= 4'd7) |-> result_we); // R5
   AST_MOV_REG: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == 4'd6 && src_sel == 2'd1) |-> result == reg_b); // R4
   AST_MVN_IMM: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode == 4'd7 && src_sel == 2'd0) |-> result == ~imm); // R4
   AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !set_flags |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R8
   AST_MOVE_CV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (set_flags && (opcode == 4'd6 || opcode == 4'd7)) |=> $stable({flag_c, flag_v})); // R9
   AST_Z_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (set_flags && opcode <= 4'd9) |=> flag_z == ($past(result) == '0)); // R7
   AST_N_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
      (set_flags && opcode <= 4'd9) |=> flag_n == $past(result[W-1])); // R7
   AST_UNDEF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode > 4'd9) |-> (!result_we && result == '0)); // R12
   AST_UNDEF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (opcode > 4'd9) |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R12

endmodule

bind tcalu_core tcalu_checker #(.W(W)) u_tcalu_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .opcode    (opcode),
   .src_sel   (src_sel),
   .reg_b     (reg_b),
   .imm       (imm),
   .set_flags (set_flags),
   .result    (result),
   .result_we (result_we),
   .flag_n    (flag_n),
   .flag_z    (flag_z),
   .flag_c    (flag_c),
   .flag_v    (flag_v)
);

// File: tb/tcalu_core_bench.sv
module tcalu_core_bench;

   localparam int W  = 8;
   localparam int SW = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [3:0]    opcode;
   logic [1:0]    src_sel;
   logic [W-1:0]  op_a;
   logic [W-1:0]  reg_b;
   logic [W-1:0]  imm;
   logic [1:0]    sh_kind;
   logic [SW-1:0] sh_amt;
   logic          set_flags;
   logic          carry_in;
   logic [W-1:0]  result;
   logic          result_we;
   logic          flag_n, flag_z, flag_c, flag_v;

   always #4 clk = ~clk;

   tcalu_core #(.W(W)) u_tcalu_core (
      .clk(clk), .rst_n(rst_n), .opcode(opcode), .src_sel(src_sel),
      .op_a(op_a), .reg_b(reg_b), .imm(imm), .sh_kind(sh_kind),
      .sh_amt(sh_amt), .set_flags(set_flags), .carry_in(carry_in),
      .result(result), .result_we(result_we),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
   );

   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done  = 1'b0;
   logic en = 1'b0, ez = 1'b0, ec = 1'b0, ev = 1'b0;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] shf(input logic [7:0] b, input logic [1:0] t, input int s);
      logic [15:0] dbl;
      dbl = {b, b} >> s;
      case (t)
         2'd0:    return b << s;
         2'd1:    return b >> s;
         2'd2:    return $signed(b) >>> s;
         default: return dbl[7:0];
      endcase
   endfunction

   function automatic string op_tag(input int op);
      if (op <= 1) return "R1";
      if (op <= 3) return "R2";
      if (op <= 5) return "R3";
      if (op <= 7) return "R4";
      if (op <= 9) return "R5";
      return "R12";
   endfunction

   task automatic run_vec(input string rtag, input int op, input logic [7:0] a,
                          input logic [7:0] b, input logic [7:0] im, input logic cin,
                          input logic sf, input logic [1:0] src, input logic [1:0] st,
                          input logic [2:0] sa);
      logic [7:0] o, er;
      logic       ewe, nc, nv;
      int         ia, io, sia, sio, cc, s, ss;
      bit         add_k;
      string      ftag;
      @(negedge clk);
      opcode = 4'(op); op_a = a; reg_b = b; imm = im; carry_in = cin;
      set_flags = sf; src_sel = src; sh_kind = st; sh_amt = sa;
      #1;
      o   = (src == 2'd0) ? im : (src == 2'd1) ? b : shf(b, st, int'(sa));
      ia  = int'(a);  io  = int'(o);
      sia = int'($signed(a)); sio = int'($signed(o));
      cc  = int'(cin);
      s = 0; ss = 0; add_k = 1'b1; er = 8'h00;
      case (op)
         0, 9: begin s = ia + io;      ss = sia + sio;      end
         1:    begin s = ia + io + cc; ss = sia + sio + cc; end
         2, 8: begin s = ia - io;      ss = sia - sio;      add_k = 1'b0; end
         3:    begin s = ia - io - (1 - cc); ss = sia - sio - (1 - cc); add_k = 1'b0; end
         4:    begin s = io - ia;      ss = sio - sia;      add_k = 1'b0; end
         5:    begin s = io - ia - (1 - cc); ss = sio - sia - (1 - cc); add_k = 1'b0; end
         default: ;
      endcase
      if (op <= 5 || op == 8 || op == 9) er = 8'(s);
      else if (op == 6) er = o;
      else if (op == 7) er = ~o;
      nc  = add_k ? (s > 255) : (s >= 0);
      nv  = (ss > 127) || (ss < -128);
      ewe = (op <= 7);
      chk({rtag, " result"}, 32'(result), 32'(er));
      chk({rtag, " write-enable"}, 32'(result_we), 32'(ewe));
      @(posedge clk);
      #1;
      if (!sf) ftag = "R8 flags";
      else if (op > 9) ftag = "R12 flags";
      else if (op == 6 || op == 7) ftag = "R9 flags";
      else ftag = "R6/R7 flags";
      if (sf && op <= 9) begin
         en = er[7];
         ez = (er == 8'h00);
         if (op != 6 && op != 7) begin
            ec = nc;
            ev = nv;
         end
      end
      chk(ftag, {28'h0, flag_n, flag_z, flag_c, flag_v}, {28'h0, en, ez, ec, ev});
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
   endtask

   initial begin
      logic [7:0] bset [8];
      bset = '{8'h00, 8'h01, 8'h7F, 8'h80, 8'h81, 8'hFE, 8'hFF, 8'h3C};
      rst_n = 1'b0; opcode = 4'd0; src_sel = 2'd0; op_a = '0; reg_b = '0;
      imm = '0; sh_kind = 2'd0; sh_amt = '0; set_flags = 1'b1; carry_in = 1'b1;
      repeat (3) @(posedge clk);
      #1;
      // R13: flags cleared during reset
      chk("R13 reset flags", {28'h0, flag_n, flag_z, flag_c, flag_v}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      // Main sweep over opcodes, all first operands, edge-heavy second operands
      for (int op = 0; op < 16; op++)
         for (int a = 0; a < 256; a++)
            for (int bi = 0; bi < 8; bi++)
               for (int c = 0; c < 2; c++)
                  run_vec(op_tag(op), op, 8'(a), bset[bi], 8'(a ^ 8'hA5), 1'(c),
                          !((a & 3) == 3), 2'd1, 2'(bi), 3'(a));

      // R11: every shift kind and distance on every register value (R10 sources 2 and 3)
      for (int b = 0; b < 256; b++)
         for (int t = 0; t < 4; t++)
            for (int s = 0; s < 8; s++)
               run_vec("R11", 6, 8'h5A, 8'(b), 8'hC3, 1'b0, 1'b0,
                       2'(2 + (s & 1)), 2'(t), 3'(s));

      // R10: immediate source with a mismatching register value, R3 negation via imm 0
      for (int i = 0; i < 256; i++) begin
         run_vec("R10", 0, 8'(i * 7), 8'(~i), 8'(i), 1'b1, 1'b1, 2'd0, 2'd0, 3'd0);
         run_vec("R10", 7, 8'h00, 8'(i + 3), 8'(i), 1'b0, 1'b1, 2'd0, 2'd1, 3'd5);
         run_vec("R3 negate", 4, 8'(i), 8'hFF, 8'h00, 1'b0, 1'b1, 2'd0, 2'd0, 3'd0);
      end

      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

endmodule